// File: doc/BRIEF.md
# Per-Lane Vector Integer ALU

This block is the integer execution datapath for a single lane of a 64-lane SIMD vector unit. It is purely combinational. It receives a 6-bit operation code, two 32-bit source operands, the lane's own index and the 64-bit wave-wide condition/carry mask. It returns a 32-bit result and a copy of the mask in which only the bit belonging to this lane can differ from the input.

The operations cover these groups:
- add and subtract, each with or without carry or borrow, including forms that swap the operands
- bitwise logic
- shifts with the operands reversed, so the shift amount comes from the first source
- signed and unsigned minimum and maximum
- 24-bit multiplies that return the low or the high half of the product
- a per-lane select that is steered by the mask bit

The carry-in, the borrow-in and the select condition are all read from the mask bit selected by the lane index. Carry-out and borrow-out are written back to that same bit. The unit is meant to be replicated once per lane, and a wave-level merge keeps each lane's mask bit.

Top module: `vlane_int_alu`

## Requirements
- R1: Opcode 25 gives result = (src0 + src1) mod 2^32 and writes the carry-out to mask bit [lane].
- R2: Opcode 28 adds src0, src1 and carry-in mask_i[lane]. The result is the low 32 bits and the carry-out goes to mask bit [lane].
- R3: Opcode 26 computes src0 - src1 and opcode 27 computes src1 - src0. Each writes mask bit [lane] = 1 exactly when the true difference is negative (unsigned borrow).
- R4: Opcode 29 computes src0 - src1 - mask_i[lane] and opcode 30 computes src1 - src0 - mask_i[lane]. Each writes the borrow-out to mask bit [lane].
- R5: Opcodes 18, 16 and 17 shift src1 by src0[4:0]: logical left, logical right and arithmetic right respectively. Bits 31:5 of src0 are ignored.
- R6: Opcodes 19, 20 and 21 return src0 AND src1, src0 OR src1 and src0 XOR src1.
- R7: Opcodes 12, 13, 14 and 15 return the signed minimum, signed maximum, unsigned minimum and unsigned maximum of src0 and src1.
- R8: Opcode 8 (unsigned) and opcode 6 (signed) multiply src0[23:0] by src1[23:0] and return bits 31:0 of the 48-bit product.
- R9: Opcode 9 (unsigned) and opcode 7 (signed) return product bits 47:32. The signed form sign-extends them to 32 bits and the unsigned form zero-extends them.
- R10: Opcode 0 returns src1 when mask_i[lane] is 1 and src0 otherwise.
- R11: mask_o differs from mask_i in no bit other than [lane]. For opcodes outside 25..30, mask_o equals mask_i exactly.
- R12: Any opcode not listed in R1..R10 returns result 0 and leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Operation code |
| src0_i | input | 32 | First source operand |
| src1_i | input | 32 | Second source operand |
| lane_i | input | 6 | Index of this lane within the wave |
| mask_i | input | 64 | Condition/carry mask, one bit per lane |
| result_o | output | 32 | Operation result |
| mask_o | output | 64 | Updated mask |

## Verification
The hardest case is proving that the carry, the borrow and the select condition come from the bit at this lane's index and from no neighbour. A broken index still passes whenever the whole mask is uniform. The stimulus therefore places the lane at the extremes 0 and 63 and uses masks that are the complement of the lane's one-hot pattern, or exactly that pattern. Under those masks every wrong bit position gives the opposite carry-in and a changed result. Randomised masks and lanes then check that no other bit of the mask ever moves.

// File: rtl/vlane_alu_pkg.sv
package vlane_alu_pkg;

  typedef enum logic [5:0] {
    OP_CSEL      = 6'd0,
    OP_MUL_I24   = 6'd6,
    OP_MULHI_I24 = 6'd7,
    OP_MUL_U24   = 6'd8,
    OP_MULHI_U24 = 6'd9,
    OP_MIN_I     = 6'd12,
    OP_MAX_I     = 6'd13,
    OP_MIN_U     = 6'd14,
    OP_MAX_U     = 6'd15,
    OP_SHR_REV   = 6'd16,
    OP_SAR_REV   = 6'd17,
    OP_SHL_REV   = 6'd18,
    OP_AND       = 6'd19,
    OP_OR        = 6'd20,
    OP_XOR       = 6'd21,
    OP_ADD       = 6'd25,
    OP_SUB       = 6'd26,
    OP_SUBR      = 6'd27,
    OP_ADDC      = 6'd28,
    OP_SUBB      = 6'd29,
    OP_SUBBR     = 6'd30
  } alu_op_e;

  typedef enum logic [2:0] {
    UNIT_NONE,
    UNIT_CSEL,
    UNIT_ARITH,
    UNIT_LOGIC,
    UNIT_CMP,
    UNIT_MUL
  } alu_unit_e;

  // arith sub: [0]=subtract [1]=swap operands [2]=use mask carry-in
  // logic sub: 0 and, 1 or, 2 xor, 3 shl, 4 shr, 5 sar
  // cmp sub:   [0]=max [1]=unsigned
  // mul sub:   [0]=signed [1]=high half
  typedef struct packed {
    alu_unit_e  unit;
    logic [2:0] sub;
    logic       wr_mask;
  } alu_dec_t;

endpackage

// File: rtl/vlane_alu_dec.sv
module vlane_alu_dec
  import vlane_alu_pkg::*;
#(
  parameter int unsigned OP_W = 6
) (
  input  logic [OP_W-1:0] op_i,
  output alu_dec_t        dec_o
);

  always_comb begin
    dec_o = '{unit: UNIT_NONE, sub: 3'd0, wr_mask: 1'b0};
    case (op_i)
      OP_CSEL:      dec_o.unit = UNIT_CSEL;
      OP_MUL_I24:   dec_o = '{unit: UNIT_MUL,   sub: 3'b001, wr_mask: 1'b0};
      OP_MULHI_I24: dec_o = '{unit: UNIT_MUL,   sub: 3'b011, wr_mask: 1'b0};
      OP_MUL_U24:   dec_o = '{unit: UNIT_MUL,   sub: 3'b000, wr_mask: 1'b0};
      OP_MULHI_U24: dec_o = '{unit: UNIT_MUL,   sub: 3'b010, wr_mask: 1'b0};
      OP_MIN_I:     dec_o = '{unit: UNIT_CMP,   sub: 3'b000, wr_mask: 1'b0};
      OP_MAX_I:     dec_o = '{unit: UNIT_CMP,   sub: 3'b001, wr_mask: 1'b0};
      OP_MIN_U:     dec_o = '{unit: UNIT_CMP,   sub: 3'b010, wr_mask: 1'b0};
      OP_MAX_U:     dec_o = '{unit: UNIT_CMP,   sub: 3'b011, wr_mask: 1'b0};
      OP_AND:       dec_o = '{unit: UNIT_LOGIC, sub: 3'd0,   wr_mask: 1'b0};
      OP_OR:        dec_o = '{unit: UNIT_LOGIC, sub: 3'd1,   wr_mask: 1'b0};
      OP_XOR:       dec_o = '{unit: UNIT_LOGIC, sub: 3'd2,   wr_mask: 1'b0};
      OP_SHL_REV:   dec_o = '{unit: UNIT_LOGIC, sub: 3'd3,   wr_mask: 1'b0};
      OP_SHR_REV:   dec_o = '{unit: UNIT_LOGIC, sub: 3'd4,   wr_mask: 1'b0};
      OP_SAR_REV:   dec_o = '{unit: UNIT_LOGIC, sub: 3'd5,   wr_mask: 1'b0};
      OP_ADD:       dec_o = '{unit: UNIT_ARITH, sub: 3'b000, wr_mask: 1'b1};
      OP_SUB:       dec_o = '{unit: UNIT_ARITH, sub: 3'b001, wr_mask: 1'b1};
      OP_SUBR:      dec_o = '{unit: UNIT_ARITH, sub: 3'b011, wr_mask: 1'b1};
      OP_ADDC:      dec_o = '{unit: UNIT_ARITH, sub: 3'b100, wr_mask: 1'b1};
      OP_SUBB:      dec_o = '{unit: UNIT_ARITH, sub: 3'b101, wr_mask: 1'b1};
      OP_SUBBR:     dec_o = '{unit: UNIT_ARITH, sub: 3'b111, wr_mask: 1'b1};
      default:      dec_o = '{unit: UNIT_NONE,  sub: 3'd0,   wr_mask: 1'b0};
    endcase
  end

endmodule

// File: rtl/vlane_alu_arith.sv
module vlane_alu_arith #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        sub_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);

  logic              is_sub, swap, use_cin, cin_eff;
  logic [DATA_W-1:0] x, y;
  logic [DATA_W:0]   wide;

  assign is_sub  = sub_i[0];
  assign swap    = sub_i[1];
  assign use_cin = sub_i[2];
  assign cin_eff = use_cin & cin_i;
  assign x       = swap ? b_i : a_i;
  assign y       = swap ? a_i : b_i;

  // top bit of the widened result is the carry (add) or the borrow (sub)
  always_comb begin
    if (is_sub) wide = {1'b0, x} - {1'b0, y} - {{DATA_W{1'b0}}, cin_eff};
    else        wide = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin_eff};
  end

  assign res_o  = wide[DATA_W-1:0];
  assign cout_o = wide[DATA_W];

endmodule

// File: rtl/vlane_alu_logic.sv
module vlane_alu_logic #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        sub_i,
  output logic [DATA_W-1:0] res_o
);

  localparam int unsigned SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] shamt;
  assign shamt = a_i[SH_W-1:0];

  always_comb begin
    case (sub_i)
      3'd0:    res_o = a_i & b_i;
      3'd1:    res_o = a_i | b_i;
      3'd2:    res_o = a_i ^ b_i;
      3'd3:    res_o = b_i << shamt;
      3'd4:    res_o = b_i >> shamt;
      3'd5:    res_o = $unsigned($signed(b_i) >>> shamt);
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/vlane_alu_cmp.sv
module vlane_alu_cmp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        sub_i,
  output logic [DATA_W-1:0] res_o
);

  logic a_lt_b;

  always_comb begin
    if (sub_i[1]) a_lt_b = a_i < b_i;
    else          a_lt_b = $signed(a_i) < $signed(b_i);
  end

  always_comb begin
    if (sub_i[0]) res_o = a_lt_b ? b_i : a_i;
    else          res_o = a_lt_b ? a_i : b_i;
  end

endmodule

// File: rtl/vlane_alu_mul.sv
module vlane_alu_mul #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MUL_W  = 24
) (
  input  logic [MUL_W-1:0]  a_i,
  input  logic [MUL_W-1:0]  b_i,
  input  logic [1:0]        sub_i,
  output logic [DATA_W-1:0] res_o
);

  localparam int unsigned PROD_W = 2 * MUL_W;
  localparam int unsigned HI_W   = PROD_W - DATA_W;
  localparam int unsigned EXT_W  = DATA_W - HI_W;

  logic              is_signed, is_hi;
  logic [PROD_W-1:0] ax, bx, prod;
  logic [DATA_W-1:0] hi_ext;

  assign is_signed = sub_i[0];
  assign is_hi     = sub_i[1];

  // operand extension to product width; low PROD_W bits of the product are exact
  assign ax   = {{MUL_W{is_signed & a_i[MUL_W-1]}}, a_i};
  assign bx   = {{MUL_W{is_signed & b_i[MUL_W-1]}}, b_i};
  assign prod = ax * bx;

  assign hi_ext = {{EXT_W{is_signed & prod[PROD_W-1]}}, prod[PROD_W-1:DATA_W]};
  assign res_o  = is_hi ? hi_ext : prod[DATA_W-1:0];

endmodule

// File: rtl/vlane_int_alu.sv
module vlane_int_alu
  import vlane_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 64,
  parameter int unsigned OP_W   = 6,
  parameter int unsigned MUL_W  = 24
) (
  input  logic [OP_W-1:0]          op_i,
  input  logic [DATA_W-1:0]        src0_i,
  input  logic [DATA_W-1:0]        src1_i,
  input  logic [$clog2(LANES)-1:0] lane_i,
  input  logic [LANES-1:0]         mask_i,
  output logic [DATA_W-1:0]        result_o,
  output logic [LANES-1:0]         mask_o
);

  localparam int unsigned LANE_W = $clog2(LANES);

  alu_dec_t          dec;
  logic              lane_bit;
  logic              arith_cout;
  logic [DATA_W-1:0] arith_res, logic_res, cmp_res, mul_res, csel_res;

  assign lane_bit = mask_i[lane_i];

  vlane_alu_dec #(.OP_W(OP_W)) u_dec (
    .op_i  (op_i),
    .dec_o (dec)
  );

  vlane_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i    (src0_i),
    .b_i    (src1_i),
    .sub_i  (dec.sub),
    .cin_i  (lane_bit),
    .res_o  (arith_res),
    .cout_o (arith_cout)
  );

  vlane_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (src0_i),
    .b_i   (src1_i),
    .sub_i (dec.sub),
    .res_o (logic_res)
  );

  vlane_alu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a_i   (src0_i),
    .b_i   (src1_i),
    .sub_i (dec.sub[1:0]),
    .res_o (cmp_res)
  );

  vlane_alu_mul #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_mul (
    .a_i   (src0_i[MUL_W-1:0]),
    .b_i   (src1_i[MUL_W-1:0]),
    .sub_i (dec.sub[1:0]),
    .res_o (mul_res)
  );

  assign csel_res = lane_bit ? src1_i : src0_i;

  always_comb begin
    case (dec.unit)
      UNIT_CSEL:  result_o = csel_res;
      UNIT_ARITH: result_o = arith_res;
      UNIT_LOGIC: result_o = logic_res;
      UNIT_CMP:   result_o = cmp_res;
      UNIT_MUL:   result_o = mul_res;
      default:    result_o = '0;
    endcase
  end

  // per-bit mask merge: only the addressed lane takes the new carry
  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign mask_o[i] = (dec.wr_mask && (lane_i == LANE_W'(i))) ? arith_cout : mask_i[i];
  end

endmodule

// File: rtl/vlane_int_alu_chk.sv
module vlane_int_alu_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 64,
  parameter int unsigned OP_W   = 6
) (
  input logic [OP_W-1:0]          op_i,
  input logic [DATA_W-1:0]        src0_i,
  input logic [DATA_W-1:0]        src1_i,
  input logic [$clog2(LANES)-1:0] lane_i,
  input logic [LANES-1:0]         mask_i,
  input logic [DATA_W-1:0]        result_o,
  input logic [LANES-1:0]         mask_o
);

  logic             carry_op, known_op;
  logic [LANES-1:0] lane_oh;
  logic [DATA_W:0]  sum_w;

  assign carry_op = (op_i >= OP_W'(25)) && (op_i <= OP_W'(30));
  assign known_op = carry_op || (op_i == '0) || ((op_i >= OP_W'(6)) && (op_i <= OP_W'(9))) ||
                    ((op_i >= OP_W'(12)) && (op_i <= OP_W'(21)));
  assign lane_oh  = {{(LANES-1){1'b0}}, 1'b1} << lane_i;
  assign sum_w    = {1'b0, src0_i} + {1'b0, src1_i};

  always_comb begin
    assert_other_bits_R11: assert (((mask_o ^ mask_i) & ~lane_oh) == '0);
    if (!carry_op) begin
      assert_mask_kept_R11: assert (mask_o == mask_i);
    end
    if (!known_op) begin
      assert_unknown_zero_R12: assert (result_o == '0);
    end
    if (op_i == '0) begin
      assert_csel_R10: assert (result_o == ((mask_i & lane_oh) != '0 ? src1_i : src0_i));
    end
    if (op_i == OP_W'(25)) begin
      assert_add_carry_R1: assert ({mask_o[lane_i], result_o} == sum_w);
    end
    if (op_i == OP_W'(26)) begin
      assert_sub_borrow_R3: assert (mask_o[lane_i] == (src1_i > src0_i));
    end
    if (op_i == OP_W'(21)) begin
      assert_xor_R6: assert (result_o == (src0_i ^ src1_i));
    end
    if (op_i == OP_W'(16)) begin
      assert_shr_rev_R5: assert (result_o == (src1_i >> src0_i[4:0]));
    end
  end

endmodule

bind vlane_int_alu vlane_int_alu_chk #(
  .DATA_W (DATA_W),
  .LANES  (LANES),
  .OP_W   (OP_W)
) u_chk (
  .op_i     (op_i),
  .src0_i   (src0_i),
  .src1_i   (src1_i),
  .lane_i   (lane_i),
  .mask_i   (mask_i),
  .result_o (result_o),
  .mask_o   (mask_o)
);

// File: tb/vlane_int_alu_bench.sv
`timescale 1ns/1ps
module vlane_int_alu_bench;

  typedef struct {
    logic [31:0] res;
    logic [63:0] mask;
    logic [5:0]  op;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  op = '0;
  logic [31:0] src0 = '0, src1 = '0;
  logic [5:0]  lane = '0;
  logic [63:0] mask = '0;
  logic [31:0] result;
  logic [63:0] mask_out;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  vlane_int_alu u_vlane_int_alu (
    .op_i     (op),
    .src0_i   (src0),
    .src1_i   (src1),
    .lane_i   (lane),
    .mask_i   (mask),
    .result_o (result),
    .mask_o   (mask_out)
  );

  function automatic string req_of(input logic [5:0] o);
    case (o)
      6'd25: return "R1";
      6'd28: return "R2";
      6'd26, 6'd27: return "R3";
      6'd29, 6'd30: return "R4";
      6'd16, 6'd17, 6'd18: return "R5";
      6'd19, 6'd20, 6'd21: return "R6";
      6'd12, 6'd13, 6'd14, 6'd15: return "R7";
      6'd6, 6'd8: return "R8";
      6'd7, 6'd9: return "R9";
      6'd0: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic void model(input logic [5:0] o, input logic [31:0] a, input logic [31:0] b,
                                input logic [5:0] ln, input logic [63:0] m,
                                output logic [31:0] r, output logic [63:0] mo);
    longint xa, xb, p, ci;
    xa = longint'({32'h0, a});
    xb = longint'({32'h0, b});
    ci = m[ln] ? 64'sd1 : 64'sd0;
    mo = m;
    r  = '0;
    case (o)
      6'd0:  r = m[ln] ? b : a;
      6'd25: begin p = xa + xb;      r = p[31:0]; mo[ln] = p[32];   end
      6'd28: begin p = xa + xb + ci; r = p[31:0]; mo[ln] = p[32];   end
      6'd26: begin p = xa - xb;      r = p[31:0]; mo[ln] = (p < 0); end
      6'd27: begin p = xb - xa;      r = p[31:0]; mo[ln] = (p < 0); end
      6'd29: begin p = xa - xb - ci; r = p[31:0]; mo[ln] = (p < 0); end
      6'd30: begin p = xb - xa - ci; r = p[31:0]; mo[ln] = (p < 0); end
      6'd18: r = b << a[4:0];
      6'd16: r = b >> a[4:0];
      6'd17: r = $unsigned($signed(b) >>> a[4:0]);
      6'd19: r = a & b;
      6'd20: r = a | b;
      6'd21: r = a ^ b;
      6'd12: r = ($signed(a) < $signed(b)) ? a : b;
      6'd13: r = ($signed(a) > $signed(b)) ? a : b;
      6'd14: r = (a < b) ? a : b;
      6'd15: r = (a > b) ? a : b;
      6'd6, 6'd7: begin
        p = longint'($signed(a[23:0])) * longint'($signed(b[23:0]));
        r = (o == 6'd6) ? p[31:0] : p[63:32];
      end
      6'd8, 6'd9: begin
        p = longint'({40'h0, a[23:0]}) * longint'({40'h0, b[23:0]});
        r = (o == 6'd8) ? p[31:0] : p[63:32];
      end
      default: r = '0;
    endcase
  endfunction

  task automatic drive(input logic [5:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [5:0] ln, input logic [63:0] m, input string rq);
    exp_t e;
    @(posedge clk);
    #1;
    op = o; src0 = a; src1 = b; lane = ln; mask = m;
    model(o, a, b, ln, m, e.res, e.mask);
    e.op  = o;
    e.req = rq;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (result !== e.res || mask_out !== e.mask) begin
        n_bad++;
        $display("FAIL %s op=%0d: result=%h mask=%h expected result=%h mask=%h",
                 e.req, e.op, result, mask_out, e.res, e.mask);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam logic [63:0] ONE = 64'h1;

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state pattern: all inputs zero
    drive(6'd0, 32'h0, 32'h0, 6'd0, 64'h0, "R10");
    // R1 carry at the top lane, carry and no carry
    drive(6'd25, 32'hFFFF_FFFF, 32'h1, 6'd63, 64'h0, "R1");
    drive(6'd25, 32'h1234_0000, 32'h0000_5678, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R1");
    // R2 carry-in from lane bit only: complement and one-hot masks
    drive(6'd28, 32'hFFFF_FFFF, 32'h0, 6'd63, ~(ONE << 63), "R2");
    drive(6'd28, 32'hFFFF_FFFF, 32'h0, 6'd63, ONE << 63, "R2");
    drive(6'd28, 32'h10, 32'h20, 6'd0, ONE, "R2");
    // R3 borrow in both orders
    drive(6'd26, 32'h5, 32'h7, 6'd17, 64'h0, "R3");
    drive(6'd27, 32'h5, 32'h7, 6'd17, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    drive(6'd26, 32'h7, 32'h7, 6'd5, ONE << 5, "R3");
    // R4 borrow-in makes equal operands borrow
    drive(6'd29, 32'h9, 32'h9, 6'd40, ONE << 40, "R4");
    drive(6'd30, 32'h9, 32'h9, 6'd40, ~(ONE << 40), "R4");
    drive(6'd30, 32'h3, 32'h0, 6'd1, ONE << 1, "R4");
    // R5 shifts, amount masked to 5 bits
    drive(6'd18, 32'hFFFF_FFE1, 32'h1, 6'd2, 64'h0, "R5");
    drive(6'd16, 32'h0000_0020, 32'h8000_0000, 6'd2, 64'h0, "R5");
    drive(6'd17, 32'h0000_001F, 32'h8000_0000, 6'd2, 64'h0, "R5");
    drive(6'd17, 32'h4, 32'h7000_0000, 6'd2, 64'h0, "R5");
    // R6 logic
    drive(6'd19, 32'hF0F0_1234, 32'hFF00_FF00, 6'd3, 64'h0, "R6");
    drive(6'd20, 32'hF0F0_1234, 32'h0F00_0001, 6'd3, 64'h0, "R6");
    drive(6'd21, 32'hAAAA_5555, 32'hFFFF_0000, 6'd3, 64'h0, "R6");
    // R7 signed vs unsigned with the sign bit set
    drive(6'd12, 32'h8000_0000, 32'h1, 6'd9, 64'h0, "R7");
    drive(6'd13, 32'h8000_0000, 32'h1, 6'd9, 64'h0, "R7");
    drive(6'd14, 32'h8000_0000, 32'h1, 6'd9, 64'h0, "R7");
    drive(6'd15, 32'h8000_0000, 32'h1, 6'd9, 64'h0, "R7");
    // R8 / R9 multiplies, upper source bits ignored
    drive(6'd8, 32'hFF80_0000, 32'h0000_0002, 6'd4, 64'h0, "R8");
    drive(6'd6, 32'h00FF_FFFF, 32'h0000_0003, 6'd4, 64'h0, "R8");
    drive(6'd9, 32'h00FF_FFFF, 32'h00FF_FFFF, 6'd4, 64'h0, "R9");
    drive(6'd7, 32'h0080_0000, 32'h007F_FFFF, 6'd4, 64'h0, "R9");
    drive(6'd7, 32'h0080_0000, 32'h0080_0000, 6'd4, 64'h0, "R9");
    // R10 select steered by lane bit only
    drive(6'd0, 32'hAAAA_AAAA, 32'h5555_5555, 6'd63, ONE << 63, "R10");
    drive(6'd0, 32'hAAAA_AAAA, 32'h5555_5555, 6'd63, ~(ONE << 63), "R10");
    // R11 non-carry op keeps a busy mask
    drive(6'd19, 32'h1, 32'h1, 6'd22, 64'hDEAD_BEEF_0123_4567, "R11");
    drive(6'd9, 32'h1, 32'h1, 6'd0, 64'hFFFF_0000_FFFF_0000, "R11");
    // R12 unassigned opcodes
    drive(6'd1, 32'h1234_5678, 32'h9ABC_DEF0, 6'd7, 64'hCAFE_F00D_1234_5678, "R12");
    drive(6'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd7, 64'h0, "R12");
    drive(6'd31, 32'hFFFF_FFFF, 32'h1, 6'd7, 64'h0, "R12");
    drive(6'd63, 32'h5, 32'h6, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF, "R12");
    // random sweep over all opcodes, lanes and masks
    for (int i = 0; i < 600; i++) begin
      logic [5:0] o;
      o = 6'($urandom_range(0, 63));
      drive(o, $urandom(), $urandom(), 6'($urandom_range(0, 63)),
            {$urandom(), $urandom()}, (o >= 6'd25 && o <= 6'd30) ? req_of(o) : "R11");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule